// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block produces the element positions that a vectorised instruction loop visits, one position per advance pulse. It keeps a source side and a destination side. Each side has a 7-bit element step and a 2-bit sub-vector step. The sub-step counts up to the inclusive limit `subVl`, so `subVl` holds the sub-vector length minus one. The element step runs from 0 to `vecLen`-1.

Each side can be predicated by its own 64-bit mask. With the predicate on and zeroing off, masked-out elements are jumped over. With zeroing on, every element is visited and a flag marks the ones whose mask bit is clear.

Setting a side's swap bit (pack on the source side, unpack on the destination side) exchanges the nesting of its two counters. The loop finishes as soon as either side runs out. A `loopEnd` flag is set and held until the next loop reset.

Top module: `elem_step_seq`

## Requirements
- R1: A reset (`rstN` low) or a `loopRst` pulse sets all four counters to 0 and clears `loopEnd`. After a reset the position is index 0, whatever bit 0 of the mask holds.
- R2: With the side's swap bit clear, an advance increments the sub-step while it differs from `subVl`. When it equals `subVl`, the advance returns the sub-step to 0 and moves the element step to the next eligible index.
- R3: With the swap bit set (`srcPack` or `dstUnpack`), an advance moves the element step to the next eligible index. When no eligible index remains below `vecLen`, the sub-step increments and the element step restarts at the first eligible index.
- R4: An advance from the last eligible element with the sub-step equal to `subVl` ends the side. Its counters return to 0 and `loopEnd` is set on that edge.
- R5: Skipping is active when the side's predicate enable is 1 and its zeroing bit is 0. Then an index is eligible only if its mask bit (bit i for element i) is 1. Otherwise every index below `vecLen` is eligible.
- R6: With predicate and zeroing both on, masked-out elements are visited. The zero flag of a side is 1 exactly when its predicate is on and the mask bit at its current step is 0.
- R7: The two sides advance independently on each pulse. `loopEnd` is set when either side ends.
- R8: If a side has no eligible index below `vecLen` (an all-zero mask under skipping, or `vecLen` = 0), `loopEnd` is set at the next clock edge without any advance.
- R9: `loopEnd` stays 1 until `loopRst` or reset. While it is 1, advance pulses leave all counters unchanged.
- R10: With the predicate enable at 0, the mask has no effect on stepping, even when the mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loopRst | input | 1 | Synchronous loop restart |
| advance | input | 1 | Step both sides by one position |
| vecLen | input | 7 | Element count of the loop |
| subVl | input | 2 | Last sub-step index (sub-vector length minus one) |
| srcPack | input | 1 | Source side: element step becomes the inner loop |
| dstUnpack | input | 1 | Destination side: element step becomes the inner loop |
| srcPredEn | input | 1 | Source predicate enable |
| srcZeroing | input | 1 | Source zeroing mode |
| srcMask | input | 64 | Source predicate mask, bit i for element i |
| dstPredEn | input | 1 | Destination predicate enable |
| dstZeroing | input | 1 | Destination zeroing mode |
| dstMask | input | 64 | Destination predicate mask, bit i for element i |
| srcStep | output | 7 | Current source element index |
| srcSub | output | 2 | Current source sub-step |
| dstStep | output | 7 | Current destination element index |
| dstSub | output | 2 | Current destination sub-step |
| srcZeroElem | output | 1 | Current source element is masked out |
| dstZeroElem | output | 1 | Current destination element is masked out |
| loopEnd | output | 1 | Loop finished, held until restart |

## Verification
Every counter is a register that drives an output directly, so a wrong next-index choice appears on the step ports one cycle after the advance that caused it. A wrong skip decision shows up as a visit to a masked index, or as an index that is passed over. A nesting error shows up as the sub-step moving when the element step should, seen at the first advance where the two orders differ. Errors in the end or empty-mask logic show up on `loopEnd` at the very edge they occur. Because that flag is sticky, the bench can still read such an error afterwards.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  typedef struct packed {
    logic clear;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/step_lane.sv
module step_lane
  import stepseq_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subVl,
  input  logic              nestSwap,
  input  logic              predEn,
  input  logic              zeroOn,
  input  logic [MASK_W-1:0] mask,
  output logic [STEP_W-1:0] step,
  output logic [SUB_W-1:0]  sub,
  output logic              zeroElem,
  output logic              endHit,
  output logic              emptyHit
);
  localparam int IDX_W = $clog2(MASK_W);

  logic              skipOn;
  logic [MASK_W-1:0] live;
  logic [STEP_W-1:0] nxtIdx, firstIdx, nStep;
  logic [SUB_W-1:0]  nSub;
  logic              found, anyLive, wrap;

  assign skipOn = predEn & ~zeroOn;
  assign live   = skipOn ? mask : '1;

  always_comb begin
    nxtIdx   = '0;
    firstIdx = '0;
    found    = 1'b0;
    anyLive  = 1'b0;
    for (int j = MASK_W - 1; j >= 0; j--) begin
      if (live[j] && (STEP_W'(j) < vecLen)) begin
        if (STEP_W'(j) > step) begin
          nxtIdx = STEP_W'(j);
          found  = 1'b1;
        end
        firstIdx = STEP_W'(j);
        anyLive  = 1'b1;
      end
    end
  end

  always_comb begin
    nStep = step;
    nSub  = sub;
    wrap  = 1'b0;
    if (!nestSwap) begin
      if (sub != subVl) begin
        nSub = sub + 1'b1;
      end else begin
        nSub = '0;
        if (found) nStep = nxtIdx;
        else       wrap  = 1'b1;
      end
    end else begin
      if (found)               nStep = nxtIdx;
      else if (sub == subVl)   wrap  = 1'b1;
      else begin
        nSub  = sub + 1'b1;
        nStep = firstIdx;
      end
    end
    if (wrap) begin
      nStep = '0;
      nSub  = '0;
    end
  end

  assign endHit   = strobe.step & wrap;
  assign emptyHit = ~anyLive;
  assign zeroElem = predEn & ~mask[step[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= '0;
      sub  <= '0;
    end else if (strobe.clear) begin
      step <= '0;
      sub  <= '0;
    end else if (strobe.step) begin
      step <= nStep;
      sub  <= nSub;
    end
  end
endmodule

// File: rtl/step_datapath.sv
module step_datapath
  import stepseq_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subVl,
  input  logic              srcPack,
  input  logic              dstUnpack,
  input  logic              srcPredEn,
  input  logic              srcZeroing,
  input  logic [MASK_W-1:0] srcMask,
  input  logic              dstPredEn,
  input  logic              dstZeroing,
  input  logic [MASK_W-1:0] dstMask,
  output logic [STEP_W-1:0] srcStep,
  output logic [SUB_W-1:0]  srcSub,
  output logic [STEP_W-1:0] dstStep,
  output logic [SUB_W-1:0]  dstSub,
  output logic              srcZeroElem,
  output logic              dstZeroElem,
  output logic              anyEnd,
  output logic              anyEmpty
);
  logic srcEnd, dstEnd, srcEmpty, dstEmpty;

  step_lane #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_srcLane (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecLen(vecLen), .subVl(subVl),
    .nestSwap(srcPack), .predEn(srcPredEn), .zeroOn(srcZeroing), .mask(srcMask),
    .step(srcStep), .sub(srcSub), .zeroElem(srcZeroElem),
    .endHit(srcEnd), .emptyHit(srcEmpty)
  );

  step_lane #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_dstLane (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecLen(vecLen), .subVl(subVl),
    .nestSwap(dstUnpack), .predEn(dstPredEn), .zeroOn(dstZeroing), .mask(dstMask),
    .step(dstStep), .sub(dstSub), .zeroElem(dstZeroElem),
    .endHit(dstEnd), .emptyHit(dstEmpty)
  );

  assign anyEnd   = srcEnd | dstEnd;
  assign anyEmpty = srcEmpty | dstEmpty;
endmodule

// File: rtl/step_control.sv
module step_control
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopRst,
  input  logic       advance,
  input  logic       anyEnd,
  input  logic       anyEmpty,
  output seqStrobe_t strobe,
  output logic       loopEnd
);
  assign strobe.clear = loopRst;
  assign strobe.step  = advance & ~loopEnd & ~loopRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  loopEnd <= 1'b0;
    else if (loopRst)           loopEnd <= 1'b0;
    else if (anyEnd | anyEmpty) loopEnd <= 1'b1;
  end
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
  import stepseq_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopRst,
  input  logic              advance,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subVl,
  input  logic              srcPack,
  input  logic              dstUnpack,
  input  logic              srcPredEn,
  input  logic              srcZeroing,
  input  logic [MASK_W-1:0] srcMask,
  input  logic              dstPredEn,
  input  logic              dstZeroing,
  input  logic [MASK_W-1:0] dstMask,
  output logic [STEP_W-1:0] srcStep,
  output logic [SUB_W-1:0]  srcSub,
  output logic [STEP_W-1:0] dstStep,
  output logic [SUB_W-1:0]  dstSub,
  output logic              srcZeroElem,
  output logic              dstZeroElem,
  output logic              loopEnd
);
  seqStrobe_t strobe;
  logic       anyEnd, anyEmpty;

  step_control u_ctrl (
    .clk(clk), .rstN(rstN), .loopRst(loopRst), .advance(advance),
    .anyEnd(anyEnd), .anyEmpty(anyEmpty), .strobe(strobe), .loopEnd(loopEnd)
  );

  step_datapath #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecLen(vecLen), .subVl(subVl),
    .srcPack(srcPack), .dstUnpack(dstUnpack),
    .srcPredEn(srcPredEn), .srcZeroing(srcZeroing), .srcMask(srcMask),
    .dstPredEn(dstPredEn), .dstZeroing(dstZeroing), .dstMask(dstMask),
    .srcStep(srcStep), .srcSub(srcSub), .dstStep(dstStep), .dstSub(dstSub),
    .srcZeroElem(srcZeroElem), .dstZeroElem(dstZeroElem),
    .anyEnd(anyEnd), .anyEmpty(anyEmpty)
  );
endmodule

// File: rtl/elem_step_seq_chk.sv
module elem_step_seq_chk #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              loopRst,
  input logic              advance,
  input logic [SUB_W-1:0]  subVl,
  input logic              srcPack,
  input logic [STEP_W-1:0] srcStep,
  input logic [SUB_W-1:0]  srcSub,
  input logic [STEP_W-1:0] dstStep,
  input logic [SUB_W-1:0]  dstSub,
  input logic              loopEnd
);
  // R9
  loopend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopEnd && !loopRst) |=> loopEnd);

  // R9
  frozen_steps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopEnd && !loopRst) |=> ($stable(srcStep) && $stable(srcSub) &&
                               $stable(dstStep) && $stable(dstSub)));

  // R1
  loop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopRst |=> (srcStep == '0 && srcSub == '0 && dstStep == '0 &&
                 dstSub == '0 && !loopEnd));

  // R2
  inner_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !loopEnd && !loopRst && !srcPack && srcSub != subVl)
      |=> (srcSub == SUB_W'($past(srcSub) + 1'b1) && $stable(srcStep)));
endmodule

bind elem_step_seq elem_step_seq_chk #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rstN(rstN), .loopRst(loopRst), .advance(advance), .subVl(subVl),
  .srcPack(srcPack), .srcStep(srcStep), .srcSub(srcSub), .dstStep(dstStep),
  .dstSub(dstSub), .loopEnd(loopEnd)
);

// File: tb/elem_step_seq_bench.sv
module elem_step_seq_bench;
  typedef struct packed {
    logic [6:0]  vl;
    logic [1:0]  sv;
    logic        sPack;
    logic        dUnp;
    logic        sPred;
    logic        sZ;
    logic [63:0] sMask;
    logic        dPred;
    logic        dZ;
    logic [63:0] dMask;
    logic [7:0]  n;
    logic [6:0]  eSS;
    logic [1:0]  eSSub;
    logic [6:0]  eDS;
    logic [1:0]  eDSub;
    logic        eEnd;
    logic        eSZ;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{7'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  1'b0, 1'b0, 64'h0,  8'd3, 7'd1, 2'd1, 7'd1, 2'd1, 1'b0, 1'b0}, // R2
    '{7'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  1'b0, 1'b0, 64'h0,  8'd8, 7'd0, 2'd0, 7'd0, 2'd0, 1'b1, 1'b0}, // R4
    '{7'd3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0,  1'b0, 1'b0, 64'h0,  8'd4, 7'd1, 2'd1, 7'd1, 2'd1, 1'b0, 1'b0}, // R3
    '{7'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0,  1'b0, 1'b0, 64'h0,  8'd4, 7'd1, 2'd1, 7'd2, 2'd0, 1'b0, 1'b0}, // R7
    '{7'd8, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 64'hA4, 1'b0, 1'b0, 64'h0,  8'd2, 7'd5, 2'd0, 7'd2, 2'd0, 1'b0, 1'b0}, // R5
    '{7'd8, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 64'hA4, 1'b0, 1'b0, 64'h0,  8'd4, 7'd0, 2'd0, 7'd4, 2'd0, 1'b1, 1'b1}, // R7
    '{7'd8, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 64'hA4, 1'b0, 1'b0, 64'h0,  8'd3, 7'd3, 2'd0, 7'd3, 2'd0, 1'b0, 1'b1}, // R6
    '{7'd4, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0,  1'b0, 1'b0, 64'h0,  8'd0, 7'd0, 2'd0, 7'd0, 2'd0, 1'b1, 1'b1}, // R8
    '{7'd4, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 64'hA,  1'b0, 1'b0, 64'h0,  8'd3, 7'd1, 2'd1, 7'd1, 2'd1, 1'b0, 1'b0}, // R3
    '{7'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  1'b0, 1'b0, 64'h0,  8'd2, 7'd2, 2'd0, 7'd2, 2'd0, 1'b0, 1'b0}, // R10
    '{7'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  1'b1, 1'b0, 64'h22, 8'd2, 7'd2, 2'd0, 7'd5, 2'd0, 1'b0, 1'b0}  // R5
  };
  string tags [NVEC] = '{"R2", "R4", "R3", "R7", "R5", "R7", "R6", "R8", "R3", "R10", "R5"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loopRst = 1'b0;
  logic        advance = 1'b0;
  logic [6:0]  vecLen = 7'd4;
  logic [1:0]  subVl = 2'd0;
  logic        srcPack = 1'b0, dstUnpack = 1'b0;
  logic        srcPredEn = 1'b0, srcZeroing = 1'b0, dstPredEn = 1'b0, dstZeroing = 1'b0;
  logic [63:0] srcMask = '0, dstMask = '0;
  logic [6:0]  srcStep, dstStep;
  logic [1:0]  srcSub, dstSub;
  logic        srcZeroElem, dstZeroElem, loopEnd;

  int runCnt = 0;
  int failCnt = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  elem_step_seq u_elem_step_seq (
    .clk(clk), .rstN(rstN), .loopRst(loopRst), .advance(advance),
    .vecLen(vecLen), .subVl(subVl), .srcPack(srcPack), .dstUnpack(dstUnpack),
    .srcPredEn(srcPredEn), .srcZeroing(srcZeroing), .srcMask(srcMask),
    .dstPredEn(dstPredEn), .dstZeroing(dstZeroing), .dstMask(dstMask),
    .srcStep(srcStep), .srcSub(srcSub), .dstStep(dstStep), .dstSub(dstSub),
    .srcZeroElem(srcZeroElem), .dstZeroElem(dstZeroElem), .loopEnd(loopEnd)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    runCnt = runCnt + 1;
    if (act != exp) begin
      failCnt = failCnt + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input string tag);
    @(negedge clk);
    vecLen = v.vl; subVl = v.sv; srcPack = v.sPack; dstUnpack = v.dUnp;
    srcPredEn = v.sPred; srcZeroing = v.sZ; srcMask = v.sMask;
    dstPredEn = v.dPred; dstZeroing = v.dZ; dstMask = v.dMask;
    loopRst = 1'b1;
    @(negedge clk);
    loopRst = 1'b0;
    for (int k = 0; k < int'(v.n); k++) begin
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0;
    @(negedge clk);
    chk(tag, "srcStep", srcStep, v.eSS);
    chk(tag, "srcSub", srcSub, v.eSSub);
    chk(tag, "dstStep", dstStep, v.eDS);
    chk(tag, "dstSub", dstSub, v.eDSub);
    chk(tag, "loopEnd", loopEnd, v.eEnd);
    chk(tag, "srcZeroElem", srcZeroElem, v.eSZ);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "srcStep at reset", srcStep, 0);
    chk("R1", "dstSub at reset", dstSub, 0);
    chk("R1", "loopEnd at reset", loopEnd, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "loopEnd after reset release", loopEnd, 0);

    for (int i = 0; i < NVEC; i++) runVec(TBL[i], tags[i]);

    // R9: finished loop ignores further advances
    runVec(TBL[1], "R4");
    advance = 1'b1;
    repeat (3) @(negedge clk);
    advance = 1'b0;
    @(negedge clk);
    chk("R9", "loopEnd held", loopEnd, 1);
    chk("R9", "srcStep frozen", srcStep, 0);
    chk("R9", "dstSub frozen", dstSub, 0);

    // R1: loop restart clears a finished loop
    loopRst = 1'b1;
    @(negedge clk);
    loopRst = 1'b0;
    chk("R1", "loopEnd after restart", loopEnd, 0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk("R1", "srcSub after restart + advance", srcSub, 1);

    // R1: restart in the middle of a run
    loopRst = 1'b1;
    @(negedge clk);
    loopRst = 1'b0;
    chk("R1", "srcSub after mid-run restart", srcSub, 0);

    // R8: zero vector length ends without advance
    vecLen = 7'd0;
    @(negedge clk);
    chk("R8", "loopEnd with zero length", loopEnd, 1);

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule